// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit turns the addressing part of an instruction into a memory location. It takes the two-bit mode field and three-bit register/memory field of an operand postbyte, plus a raw displacement. It also takes the present contents of the two base registers (BX, BP), the two index registers (SI, DI) and the four segment registers. From these it computes three results: the 16-bit effective offset, the segment that applies to the access, and the 20-bit physical address. The physical address is the segment value moved up four bit places, with the offset added to it.

The default segment depends on the addressing form. Forms built on BP use the stack segment and every other memory form uses the data segment. An optional override replaces that default. Mode 00 with r/m 110 is a special case: it gives a direct address made only from the 16-bit displacement. Mode 11 does not address memory at all. In that mode the unit reports register-direct operation and returns the register number. All outputs pass through one register stage, so each result appears one clock after its inputs are presented with `in_valid`.

Top module: `seg_ea_gen`

## Requirements
- R1: For memory modes (00, 01, 10) the r/m field picks the base/index sum before displacement: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP (except the direct case of R2), 111 BX.
- R2: With mode 00 and r/m 110 the offset is the full 16-bit displacement alone, and the default segment is the data segment (code 11).
- R3: Mode 00 (other r/m) adds no displacement. Mode 01 adds displacement bits 7:0 sign-extended to 16 bits, and its bits 15:8 have no effect. Mode 10 adds the full 16-bit displacement.
- R4: Without override, r/m 010, 011, and r/m 110 in modes 01/10 select the stack segment (code 10). All other memory forms select the data segment (code 11).
- R5: When `ovr_en` is 1, `ovr_sel` replaces the default segment, with codes 00 extra, 01 code, 10 stack, 11 data. `seg_value` carries the chosen segment register.
- R6: The offset sum wraps modulo 2^16.
- R7: `phys_addr` equals (`seg_value` * 16 + `ea_offset`) modulo 2^20.
- R8: Mode 11 sets `reg_direct`=1 and `reg_num`=r/m, with `mem_valid`=0. In that case `ea_offset`, `seg_code`, `seg_value` and `phys_addr` are 0. In memory modes `reg_num` is 0.
- R9: Outputs reflect the inputs sampled at the previous rising edge. `out_valid` follows `in_valid` with one cycle of latency. A cycle without `in_valid` yields `out_valid`, `mem_valid` and `reg_direct` all 0 and zero data outputs.
- R10: The synchronous active-high `rst` clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry a request this cycle |
| ea_mode | input | 2 | Postbyte mode field |
| ea_rm | input | 3 | Postbyte register/memory field |
| disp | input | 16 | Raw displacement (low byte used in mode 01) |
| reg_bx | input | 16 | BX contents |
| reg_bp | input | 16 | BP contents |
| reg_si | input | 16 | SI contents |
| reg_di | input | 16 | DI contents |
| seg_es | input | 16 | Extra segment register |
| seg_cs | input | 16 | Code segment register |
| seg_ss | input | 16 | Stack segment register |
| seg_ds | input | 16 | Data segment register |
| ovr_en | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code |
| out_valid | output | 1 | Registered result present |
| mem_valid | output | 1 | Result is a memory address |
| reg_direct | output | 1 | Result is a register operand |
| reg_num | output | 3 | Register number in register-direct mode |
| ea_offset | output | 16 | Effective offset |
| seg_code | output | 2 | Selected segment code |
| seg_value | output | 16 | Selected segment register value |
| phys_addr | output | 20 | Physical address |

## Verification
The bench sweeps every mode and r/m combination against three register sets. Each sweep runs with no override and with each of the four override codes, so default-segment selection is told apart from override replacement. The displacement patterns are 0x0080, 0x7F12 and 0xFFFF. Running them in mode 01 shows whether the unit sign-extends the low byte and drops the high byte; mode 00 shows that the displacement is ignored. One register set holds values near 0xFFFF to force offset wrap and 20-bit physical wrap. Idle cycles and the reset state are checked separately.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;
  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } seg_code_e;

  localparam logic [1:0] MODE_NODISP = 2'b00;
  localparam logic [1:0] MODE_DISP8  = 2'b01;
  localparam logic [1:0] MODE_DISP16 = 2'b10;
  localparam logic [1:0] MODE_REG    = 2'b11;
  localparam logic [2:0] RM_BP_ALONE = 3'b110;
  localparam int         NUM_SEGS    = 4;
endpackage

// File: rtl/ea_offset_calc.sv
module ea_offset_calc
  import seg_ea_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic [1:0]       mode,
  input  logic [2:0]       rm,
  input  logic [OFS_W-1:0] disp,
  input  logic [OFS_W-1:0] bx,
  input  logic [OFS_W-1:0] bp,
  input  logic [OFS_W-1:0] si,
  input  logic [OFS_W-1:0] di,
  output logic [OFS_W-1:0] offset
);
  localparam int EXT_W = OFS_W - 8;

  logic [OFS_W-1:0] base_term;
  logic [OFS_W-1:0] index_term;
  logic [OFS_W-1:0] disp_term;
  logic             direct_form;

  assign direct_form = (mode == MODE_NODISP) && (rm == RM_BP_ALONE);

  always_comb begin
    base_term  = '0;
    index_term = '0;
    unique case (rm)
      3'b000: begin base_term = bx; index_term = si; end
      3'b001: begin base_term = bx; index_term = di; end
      3'b010: begin base_term = bp; index_term = si; end
      3'b011: begin base_term = bp; index_term = di; end
      3'b100: index_term = si;
      3'b101: index_term = di;
      3'b110: base_term = direct_form ? '0 : bp;
      default: base_term = bx;
    endcase
  end

  always_comb begin
    unique case (mode)
      MODE_DISP8:  disp_term = {{EXT_W{disp[7]}}, disp[7:0]};
      MODE_DISP16: disp_term = disp;
      MODE_NODISP: disp_term = direct_form ? disp : '0;
      default:     disp_term = '0;
    endcase
  end

  assign offset = base_term + index_term + disp_term;
endmodule

// File: rtl/ea_seg_select.sv
module ea_seg_select
  import seg_ea_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic [1:0]       mode,
  input  logic [2:0]       rm,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_sel,
  input  logic [SEG_W-1:0] seg_es,
  input  logic [SEG_W-1:0] seg_cs,
  input  logic [SEG_W-1:0] seg_ss,
  input  logic [SEG_W-1:0] seg_ds,
  output seg_code_e        code,
  output logic [SEG_W-1:0] value
);
  logic [SEG_W-1:0] seg_bank [NUM_SEGS];
  logic             bp_form;
  seg_code_e        dflt;

  assign seg_bank[0] = seg_es;
  assign seg_bank[1] = seg_cs;
  assign seg_bank[2] = seg_ss;
  assign seg_bank[3] = seg_ds;

  always_comb begin
    unique case (rm)
      3'b010, 3'b011: bp_form = 1'b1;
      3'b110:         bp_form = (mode != MODE_NODISP);
      default:        bp_form = 1'b0;
    endcase
  end

  assign dflt  = bp_form ? SEG_STACK : SEG_DATA;
  assign code  = ovr_en ? seg_code_e'(ovr_sel) : dflt;
  assign value = seg_bank[code];
endmodule

// File: rtl/ea_phys_calc.sv
module ea_phys_calc #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
  input  logic [OFS_W-1:0]  seg_val,
  input  logic [OFS_W-1:0]  offset,
  output logic [PHYS_W-1:0] phys
);
  logic [PHYS_W-1:0] seg_scaled;
  logic [PHYS_W-1:0] ofs_ext;

  assign seg_scaled = {seg_val, {SEG_SHIFT{1'b0}}};
  assign ofs_ext    = {{SEG_SHIFT{1'b0}}, offset};
  assign phys       = seg_scaled + ofs_ext;
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
  import seg_ea_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        ea_mode,
  input  logic [2:0]        ea_rm,
  input  logic [OFS_W-1:0]  disp,
  input  logic [OFS_W-1:0]  reg_bx,
  input  logic [OFS_W-1:0]  reg_bp,
  input  logic [OFS_W-1:0]  reg_si,
  input  logic [OFS_W-1:0]  reg_di,
  input  logic [OFS_W-1:0]  seg_es,
  input  logic [OFS_W-1:0]  seg_cs,
  input  logic [OFS_W-1:0]  seg_ss,
  input  logic [OFS_W-1:0]  seg_ds,
  input  logic              ovr_en,
  input  logic [1:0]        ovr_sel,
  output logic              out_valid,
  output logic              mem_valid,
  output logic              reg_direct,
  output logic [2:0]        reg_num,
  output logic [OFS_W-1:0]  ea_offset,
  output logic [1:0]        seg_code,
  output logic [OFS_W-1:0]  seg_value,
  output logic [PHYS_W-1:0] phys_addr
);
  logic [OFS_W-1:0]  ofs_c;
  seg_code_e         code_c;
  logic [OFS_W-1:0]  segv_c;
  logic [PHYS_W-1:0] phys_c;
  logic              is_reg_c;
  logic              is_mem_c;

  ea_offset_calc #(.OFS_W(OFS_W)) u_ofs (
    .mode(ea_mode), .rm(ea_rm), .disp(disp),
    .bx(reg_bx), .bp(reg_bp), .si(reg_si), .di(reg_di),
    .offset(ofs_c)
  );

  ea_seg_select #(.SEG_W(OFS_W)) u_seg (
    .mode(ea_mode), .rm(ea_rm), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .code(code_c), .value(segv_c)
  );

  ea_phys_calc #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_phys (
    .seg_val(segv_c), .offset(ofs_c), .phys(phys_c)
  );

  assign is_reg_c = in_valid && (ea_mode == MODE_REG);
  assign is_mem_c = in_valid && (ea_mode != MODE_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      mem_valid  <= 1'b0;
      reg_direct <= 1'b0;
      reg_num    <= '0;
      ea_offset  <= '0;
      seg_code   <= '0;
      seg_value  <= '0;
      phys_addr  <= '0;
    end else begin
      out_valid  <= in_valid;
      mem_valid  <= is_mem_c;
      reg_direct <= is_reg_c;
      reg_num    <= is_reg_c ? ea_rm : 3'b000;
      ea_offset  <= is_mem_c ? ofs_c : '0;
      seg_code   <= is_mem_c ? 2'(code_c) : 2'b00;
      seg_value  <= is_mem_c ? segv_c : '0;
      phys_addr  <= is_mem_c ? phys_c : '0;
    end
  end
endmodule

// File: rtl/seg_ea_gen_chk.sv
module seg_ea_gen_chk #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        ea_mode,
  input logic [2:0]        ea_rm,
  input logic [OFS_W-1:0]  disp,
  input logic [OFS_W-1:0]  seg_es,
  input logic [OFS_W-1:0]  seg_ds,
  input logic              ovr_en,
  input logic [1:0]        ovr_sel,
  input logic              out_valid,
  input logic              mem_valid,
  input logic              reg_direct,
  input logic [2:0]        reg_num,
  input logic [OFS_W-1:0]  ea_offset,
  input logic [1:0]        seg_code,
  input logic [OFS_W-1:0]  seg_value,
  input logic [PHYS_W-1:0] phys_addr
);
  // R8
  kind_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_valid && reg_direct));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !mem_valid && !reg_direct));

  // R8
  regdir_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ea_mode == 2'b11) |=>
      (reg_direct && reg_num == $past(ea_rm) && ea_offset == '0 && phys_addr == '0));

  // R2
  direct_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ea_mode == 2'b00 && ea_rm == 3'b110 && !ovr_en) |=>
      (ea_offset == $past(disp) && seg_code == 2'b11 && seg_value == $past(seg_ds)));

  // R5
  ovr_extra_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ea_mode != 2'b11 && ovr_en && ovr_sel == 2'b00) |=>
      (seg_code == 2'b00 && seg_value == $past(seg_es)));

  // R7
  phys_sum_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (phys_addr == ({seg_value, {SEG_SHIFT{1'b0}}} +
                                 {{SEG_SHIFT{1'b0}}, ea_offset})));
endmodule

bind seg_ea_gen seg_ea_gen_chk #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .ea_mode(ea_mode), .ea_rm(ea_rm),
  .disp(disp), .seg_es(seg_es), .seg_ds(seg_ds), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
  .out_valid(out_valid), .mem_valid(mem_valid), .reg_direct(reg_direct),
  .reg_num(reg_num), .ea_offset(ea_offset), .seg_code(seg_code),
  .seg_value(seg_value), .phys_addr(phys_addr)
);

// File: tb/seg_ea_gen_test.sv
`timescale 1ns/1ps
module seg_ea_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  ea_mode = '0;
  logic [2:0]  ea_rm = '0;
  logic [15:0] disp = '0;
  logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
  logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
  logic        ovr_en = 1'b0;
  logic [1:0]  ovr_sel = '0;
  logic        out_valid, mem_valid, reg_direct;
  logic [2:0]  reg_num;
  logic [15:0] ea_offset, seg_value;
  logic [1:0]  seg_code;
  logic [19:0] phys_addr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  seg_ea_gen uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ea_mode(ea_mode), .ea_rm(ea_rm),
    .disp(disp), .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel), .out_valid(out_valid), .mem_valid(mem_valid),
    .reg_direct(reg_direct), .reg_num(reg_num), .ea_offset(ea_offset),
    .seg_code(seg_code), .seg_value(seg_value), .phys_addr(phys_addr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (mode=%0d rm=%0d ovr=%0b/%0d disp=%0h)",
               req, act, exp, ea_mode, ea_rm, ovr_en, ovr_sel, disp);
    end
  endtask

  task automatic load_set(input int s);
    case (s)
      0: begin reg_bx=16'h1234; reg_bp=16'h2000; reg_si=16'h0010; reg_di=16'h0300;
               seg_es=16'h1000; seg_cs=16'h2000; seg_ss=16'h3000; seg_ds=16'h4000; end
      1: begin reg_bx=16'hFFFF; reg_bp=16'hFFF0; reg_si=16'h0002; reg_di=16'h0020;
               seg_es=16'hFFFF; seg_cs=16'hF000; seg_ss=16'hFFFE; seg_ds=16'h0001; end
      default: begin reg_bx=16'h8000; reg_bp=16'h7FFF; reg_si=16'h8000; reg_di=16'h0001;
               seg_es=16'h0ABC; seg_cs=16'h1234; seg_ss=16'h0000; seg_ds=16'hABCD; end
    endcase
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] e_ofs, e_base, e_disp, e_segv;
    logic [1:0]  e_code;
    logic [19:0] e_phys;
    string       tag;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10", {out_valid, mem_valid, reg_direct, reg_num}, 0);
    check("R10", {ea_offset, seg_code, seg_value, phys_addr}, 0);
    rst = 1'b0;

    for (int s = 0; s < 3; s++) begin
      load_set(s);
      for (int dp = 0; dp < 3; dp++) begin
        disp = (dp == 0) ? 16'h0080 : (dp == 1) ? 16'h7F12 : 16'hFFFF;
        for (int md = 0; md < 4; md++) begin
          for (int rm = 0; rm < 8; rm++) begin
            for (int ov = 0; ov < 5; ov++) begin
              ea_mode = 2'(md); ea_rm = 3'(rm);
              ovr_en = (ov != 0); ovr_sel = (ov != 0) ? 2'(ov - 1) : 2'b00;
              in_valid = 1'b1;
              // expected model from R1..R7
              case (rm)
                0: e_base = reg_bx + reg_si;
                1: e_base = reg_bx + reg_di;
                2: e_base = reg_bp + reg_si;
                3: e_base = reg_bp + reg_di;
                4: e_base = reg_si;
                5: e_base = reg_di;
                6: e_base = (md == 0) ? 16'h0000 : reg_bp;
                default: e_base = reg_bx;
              endcase
              if (md == 1) e_disp = {{8{disp[7]}}, disp[7:0]};
              else if (md == 2) e_disp = disp;
              else if (md == 0 && rm == 6) e_disp = disp;
              else e_disp = 16'h0000;
              e_ofs = e_base + e_disp;
              if (ovr_en) e_code = ovr_sel;
              else if (rm == 2 || rm == 3 || (rm == 6 && md != 0)) e_code = 2'b10;
              else e_code = 2'b11;
              case (e_code)
                2'b00: e_segv = seg_es;
                2'b01: e_segv = seg_cs;
                2'b10: e_segv = seg_ss;
                default: e_segv = seg_ds;
              endcase
              e_phys = {e_segv, 4'h0} + {4'h0, e_ofs};
              @(posedge clk);
              @(negedge clk);
              check("R9", {63'd0, out_valid}, 1);
              if (md == 3) begin
                // R8: register-direct outcome
                check("R8", {mem_valid, reg_direct, reg_num}, {1'b0, 1'b1, 3'(rm)});
                check("R8", {ea_offset, seg_code, seg_value, phys_addr}, 0);
              end else begin
                if (md == 0 && rm == 6) tag = "R2";
                else if (md == 1) tag = "R3";
                else if (s == 1) tag = "R6";
                else tag = "R1";
                check(tag, {mem_valid, reg_direct, reg_num, ea_offset}, {1'b1, 1'b0, 3'b000, e_ofs});
                tag = ovr_en ? "R5" : "R4";
                check(tag, {seg_code, seg_value}, {e_code, e_segv});
                check("R7", {44'd0, phys_addr}, {44'd0, e_phys});
              end
            end
          end
        end
      end
      // R9: idle cycle yields no valid flags and zero data
      in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R9", {out_valid, mem_valid, reg_direct, reg_num}, 0);
      check("R9", {ea_offset, seg_code, phys_addr}, 0);
    end

    // R10: synchronous reset mid-run clears outputs
    in_valid = 1'b1; ea_mode = 2'b10; ea_rm = 3'b000;
    @(posedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10", {out_valid, mem_valid, phys_addr}, 0);
    rst = 1'b0; in_valid = 1'b0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule